// File: doc/BRIEF.md
# Dual-Clock Job Stack

A per-node store for pending jobs, kept in last-in-first-out order and shared by two agents that run on clocks with no fixed relation. The local processor pushes the jobs it creates and pops the jobs it is about to run. The load-balancing fabric pops a stored job to send it to another node, or pushes a job that another node sends here. Each job is one 32-bit word. The default capacity is 1024 words.

The storage, the stack pointer and the final decision on every operation belong to the processor clock domain. A fabric request crosses into that domain through a toggle handshake. It runs there in the first cycle in which the processor asks for nothing, and its result returns the same way. The occupancy is Gray-coded in the processor domain, passed through two-flop synchronisers, and decoded in the fabric domain. The fabric port can then offer a live job count to the node's selection logic on every fabric cycle. A job that the processor has popped is gone from the store, so the fabric can only move jobs that are still stored.

Top module: `dc_job_stack`

## Requirements
- R1: After reset both occupancy outputs read 0, both empty flags are high, both full flags are low, the fabric port is not busy, and no data-valid, done or error pulse is raised.
- R2: A processor push (push high, pop low) with the stack not full stores the 32-bit word, and the processor count rises by one on the next cycle. A processor pop (pop high, push low) with the stack not empty raises `cpu_rvalid_o` for one cycle, one cycle after the request, with the most recently stored word that is still present. The count then falls by one.
- R3: A processor push while the stack holds DEPTH words, or a processor pop while it holds none, changes nothing. One cycle later it raises `cpu_err_o` for exactly one cycle, and the refused pop gives no `cpu_rvalid_o`.
- R4: A processor push and pop in the same cycle hand the pushed word straight back. `cpu_rvalid_o` rises with that word one cycle later, and the count and stored words stay as they were, whether the stack is empty, partly filled or full.
- R5: The fabric count output equals the processor count once the processor side has been idle for a few fabric cycles. The count is carried as a Gray code, so it moves by at most one step for each processor-domain change. It never exceeds DEPTH.
- R6: A fabric pop accepted while the fabric count is non-zero raises `fab_busy_o` on the next fabric cycle. Later it ends with a one-cycle `fab_done_o`, with `fab_err_o` low and `fab_rdata_o` holding the word that was on top of the stack. That word is removed. If pop and push are both high, the request is a pop.
- R7: A fabric push accepted while the fabric full flag is low places its word on top of the stack. It completes with `fab_done_o` and no error, and the next processor pop returns that word.
- R8: A fabric pop while the fabric count is 0, or a fabric push while the fabric full flag is high, is refused at the port. `fab_err_o` pulses on the next fabric cycle, and `fab_busy_o` and `fab_done_o` stay low.
- R9: Fabric requests made while `fab_busy_o` is high are ignored and leave the stored count unchanged.
- R10: If a fabric request reaches the store after the processor has already taken the last word, the store refuses it. It completes with `fab_done_o` and `fab_err_o` together, and the stack is never popped below empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Processor-side clock |
| cpu_rst_ni | input | 1 | Processor-side asynchronous reset, active low |
| cpu_push_i | input | 1 | Processor push request |
| cpu_pop_i | input | 1 | Processor pop request |
| cpu_wdata_i | input | 32 | Job word to push |
| cpu_rdata_o | output | 32 | Popped job word |
| cpu_rvalid_o | output | 1 | One-cycle strobe for cpu_rdata_o |
| cpu_err_o | output | 1 | One-cycle pulse for a refused processor request |
| cpu_full_o | output | 1 | Stack holds DEPTH words |
| cpu_empty_o | output | 1 | Stack holds no words |
| cpu_count_o | output | clog2(DEPTH+1) | Occupancy in the processor domain |
| fab_clk_i | input | 1 | Fabric-side clock |
| fab_rst_ni | input | 1 | Fabric-side asynchronous reset, active low |
| fab_push_i | input | 1 | Fabric push request |
| fab_pop_i | input | 1 | Fabric pop request |
| fab_wdata_i | input | 32 | Job word arriving from the fabric |
| fab_rdata_o | output | 32 | Job word sent out by the last fabric pop |
| fab_busy_o | output | 1 | A fabric request is in flight |
| fab_done_o | output | 1 | One-cycle completion strobe |
| fab_err_o | output | 1 | One-cycle pulse for a refused fabric request |
| fab_full_o | output | 1 | Synchronised count equals DEPTH |
| fab_empty_o | output | 1 | Synchronised count is zero |
| fab_count_o | output | clog2(DEPTH+1) | Synchronised occupancy for the selectors |

## Verification
The assertions check the following on every cycle. The processor count never jumps by more than one or passes DEPTH. Refused processor pushes and pops produce their error pulse, and a same-cycle push and pop returns its own word. On the fabric side, a pop that sees an empty count is refused at the port, busy holds until done, and done only follows busy. Other behaviours only show in the bench's scenarios. These include LIFO order across both ports, a job pushed by the fabric being the next one the processor pops, the synchronised count settling to the processor count, requests made while busy being ignored, and the race where the processor takes the last job while a fabric pop is crossing.

// File: rtl/jobstk_pkg.sv
package jobstk_pkg;
  localparam int unsigned JOB_W = 32;
  typedef logic [JOB_W-1:0] job_t;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/jobstk_sync.sv
module jobstk_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/jobstk_store.sv
module jobstk_store
  import jobstk_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  job_t          wdata_i,
  output job_t          rdata_o,
  output logic          rvalid_o,
  output logic          err_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_gray_o,
  // fabric request, already synchronised toggle plus stable operands
  input  logic          freq_tgl_i,
  input  logic          fop_pop_i,
  input  job_t          fop_wdata_i,
  output logic          fack_tgl_o,
  output logic          fres_ok_o,
  output job_t          fres_data_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  job_t          mem [DEPTH];
  logic [CW-1:0] count_q, count_d;
  logic          full, empty, pending, fexec, we;
  logic [AW-1:0] waddr, raddr;
  job_t          wd;

  assign full    = (count_q == FULL_CNT);
  assign empty   = (count_q == '0);
  assign pending = (freq_tgl_i != fack_tgl_o);
  assign waddr   = count_q[AW-1:0];
  assign raddr   = AW'(count_q - CW'(1));

  always_comb begin
    count_d = count_q;
    we      = 1'b0;
    wd      = wdata_i;
    fexec   = 1'b0;
    if (push_i && pop_i) begin
      count_d = count_q;  // pass-through
    end else if (push_i) begin
      if (!full) begin
        we      = 1'b1;
        count_d = count_q + CW'(1);
      end
    end else if (pop_i) begin
      if (!empty) count_d = count_q - CW'(1);
    end else if (pending) begin
      fexec = 1'b1;
      if (fop_pop_i) begin
        if (!empty) count_d = count_q - CW'(1);
      end else if (!full) begin
        we      = 1'b1;
        wd      = fop_wdata_i;
        count_d = count_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (we) mem[waddr] <= wd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q      <= '0;
      count_gray_o <= '0;
      rdata_o      <= '0;
      rvalid_o     <= 1'b0;
      err_o        <= 1'b0;
      fack_tgl_o   <= 1'b0;
      fres_ok_o    <= 1'b0;
      fres_data_o  <= '0;
    end else begin
      count_q      <= count_d;
      count_gray_o <= CW'(bin2gray(32'(count_d)));
      rvalid_o     <= (push_i && pop_i) || (pop_i && !push_i && !empty);
      err_o        <= (push_i && !pop_i && full) || (pop_i && !push_i && empty);
      if (push_i && pop_i)           rdata_o <= wdata_i;
      else if (pop_i && !empty)      rdata_o <= mem[raddr];
      if (fexec) begin
        fack_tgl_o <= freq_tgl_i;
        fres_ok_o  <= fop_pop_i ? !empty : !full;
        if (fop_pop_i && !empty) fres_data_o <= mem[raddr];
      end
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/jobstk_fab_port.sv
module jobstk_fab_port
  import jobstk_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  job_t          wdata_i,
  input  logic [CW-1:0] count_gray_i,
  input  logic          ack_tgl_i,
  input  logic          res_ok_i,
  input  job_t          res_data_i,
  output logic          req_tgl_o,
  output logic          op_pop_o,
  output job_t          op_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output job_t          rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  assign count_o = CW'(gray2bin(32'(count_gray_i)));
  assign full_o  = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_tgl_o  <= 1'b0;
      op_pop_o   <= 1'b0;
      op_wdata_o <= '0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      rdata_o    <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (busy_o) begin
        if (ack_tgl_i == req_tgl_o) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          err_o  <= !res_ok_i;
          if (op_pop_o && res_ok_i) rdata_o <= res_data_i;
        end
      end else if (pop_i) begin
        if (empty_o) err_o <= 1'b1;
        else begin
          op_pop_o  <= 1'b1;
          req_tgl_o <= !req_tgl_o;
          busy_o    <= 1'b1;
        end
      end else if (push_i) begin
        if (full_o) err_o <= 1'b1;
        else begin
          op_pop_o   <= 1'b0;
          op_wdata_o <= wdata_i;
          req_tgl_o  <= !req_tgl_o;
          busy_o     <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dc_job_stack.sv
module dc_job_stack
  import jobstk_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          cpu_clk_i,
  input  logic          cpu_rst_ni,
  input  logic          cpu_push_i,
  input  logic          cpu_pop_i,
  input  logic [31:0]   cpu_wdata_i,
  output logic [31:0]   cpu_rdata_o,
  output logic          cpu_rvalid_o,
  output logic          cpu_err_o,
  output logic          cpu_full_o,
  output logic          cpu_empty_o,
  output logic [CW-1:0] cpu_count_o,
  input  logic          fab_clk_i,
  input  logic          fab_rst_ni,
  input  logic          fab_push_i,
  input  logic          fab_pop_i,
  input  logic [31:0]   fab_wdata_i,
  output logic [31:0]   fab_rdata_o,
  output logic          fab_busy_o,
  output logic          fab_done_o,
  output logic          fab_err_o,
  output logic          fab_full_o,
  output logic          fab_empty_o,
  output logic [CW-1:0] fab_count_o
);
  logic          req_tgl, req_tgl_s, ack_tgl, ack_tgl_s, op_pop, res_ok;
  job_t          op_wdata, res_data;
  logic [CW-1:0] gray_c, gray_s;

  jobstk_store #(.DEPTH(DEPTH)) i_store (
    .clk_i        (cpu_clk_i),
    .rst_ni       (cpu_rst_ni),
    .push_i       (cpu_push_i),
    .pop_i        (cpu_pop_i),
    .wdata_i      (cpu_wdata_i),
    .rdata_o      (cpu_rdata_o),
    .rvalid_o     (cpu_rvalid_o),
    .err_o        (cpu_err_o),
    .count_o      (cpu_count_o),
    .count_gray_o (gray_c),
    .freq_tgl_i   (req_tgl_s),
    .fop_pop_i    (op_pop),
    .fop_wdata_i  (op_wdata),
    .fack_tgl_o   (ack_tgl),
    .fres_ok_o    (res_ok),
    .fres_data_o  (res_data)
  );

  assign cpu_full_o  = (cpu_count_o == CW'(DEPTH));
  assign cpu_empty_o = (cpu_count_o == '0);

  jobstk_sync #(.W(1)) i_req_sync (
    .clk_i(cpu_clk_i), .rst_ni(cpu_rst_ni), .d_i(req_tgl), .q_o(req_tgl_s));
  jobstk_sync #(.W(1)) i_ack_sync (
    .clk_i(fab_clk_i), .rst_ni(fab_rst_ni), .d_i(ack_tgl), .q_o(ack_tgl_s));
  jobstk_sync #(.W(CW)) i_cnt_sync (
    .clk_i(fab_clk_i), .rst_ni(fab_rst_ni), .d_i(gray_c), .q_o(gray_s));

  jobstk_fab_port #(.DEPTH(DEPTH)) i_fab (
    .clk_i        (fab_clk_i),
    .rst_ni       (fab_rst_ni),
    .push_i       (fab_push_i),
    .pop_i        (fab_pop_i),
    .wdata_i      (fab_wdata_i),
    .count_gray_i (gray_s),
    .ack_tgl_i    (ack_tgl_s),
    .res_ok_i     (res_ok),
    .res_data_i   (res_data),
    .req_tgl_o    (req_tgl),
    .op_pop_o     (op_pop),
    .op_wdata_o   (op_wdata),
    .busy_o       (fab_busy_o),
    .done_o       (fab_done_o),
    .err_o        (fab_err_o),
    .rdata_o      (fab_rdata_o),
    .count_o      (fab_count_o),
    .full_o       (fab_full_o),
    .empty_o      (fab_empty_o)
  );
endmodule

// File: rtl/dc_job_stack_chk.sv
module dc_job_stack_chk #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          cpu_clk_i,
  input logic          cpu_rst_ni,
  input logic          cpu_push_i,
  input logic          cpu_pop_i,
  input logic [31:0]   cpu_wdata_i,
  input logic [31:0]   cpu_rdata_o,
  input logic          cpu_rvalid_o,
  input logic          cpu_err_o,
  input logic          cpu_full_o,
  input logic          cpu_empty_o,
  input logic [CW-1:0] cpu_count_o,
  input logic          fab_clk_i,
  input logic          fab_rst_ni,
  input logic          fab_push_i,
  input logic          fab_pop_i,
  input logic [31:0]   fab_wdata_i,
  input logic [31:0]   fab_rdata_o,
  input logic          fab_busy_o,
  input logic          fab_done_o,
  input logic          fab_err_o,
  input logic          fab_full_o,
  input logic          fab_empty_o,
  input logic [CW-1:0] fab_count_o
);
  a_r2_count_step: assert property (@(posedge cpu_clk_i) disable iff (!cpu_rst_ni)
    (cpu_count_o == $past(cpu_count_o)) || (cpu_count_o == $past(cpu_count_o) + CW'(1)) ||
    (cpu_count_o == $past(cpu_count_o) - CW'(1)));

  a_r3_no_overflow: assert property (@(posedge cpu_clk_i) disable iff (!cpu_rst_ni)
    cpu_count_o <= CW'(DEPTH));

  a_r3_full_push_err: assert property (@(posedge cpu_clk_i) disable iff (!cpu_rst_ni)
    cpu_full_o && cpu_push_i && !cpu_pop_i |=> cpu_err_o && cpu_full_o);

  a_r3_empty_pop_err: assert property (@(posedge cpu_clk_i) disable iff (!cpu_rst_ni)
    cpu_empty_o && cpu_pop_i && !cpu_push_i |=> cpu_err_o && !cpu_rvalid_o);

  a_r4_pass_through: assert property (@(posedge cpu_clk_i) disable iff (!cpu_rst_ni)
    cpu_push_i && cpu_pop_i |=> cpu_rvalid_o && (cpu_rdata_o == $past(cpu_wdata_i)) &&
    (cpu_count_o == $past(cpu_count_o)));

  a_r5_fab_bound: assert property (@(posedge fab_clk_i) disable iff (!fab_rst_ni)
    fab_count_o <= CW'(DEPTH));

  a_r6_done_after_busy: assert property (@(posedge fab_clk_i) disable iff (!fab_rst_ni)
    fab_done_o |-> !fab_busy_o && $past(fab_busy_o));

  a_r8_refuse_empty: assert property (@(posedge fab_clk_i) disable iff (!fab_rst_ni)
    !fab_busy_o && fab_pop_i && fab_empty_o |=> fab_err_o && !fab_busy_o && !fab_done_o);

  a_r9_busy_hold: assert property (@(posedge fab_clk_i) disable iff (!fab_rst_ni)
    fab_busy_o |=> fab_busy_o || fab_done_o);
endmodule

bind dc_job_stack dc_job_stack_chk #(.DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_dc_job_stack.sv
module test_dc_job_stack;
  localparam int unsigned D  = 16;
  localparam int unsigned CW = $clog2(D + 1);

  logic cpu_clk = 1'b0, fab_clk = 1'b0, cpu_rst_n = 1'b0, fab_rst_n = 1'b0;
  logic cpu_push = 0, cpu_pop = 0, fab_push = 0, fab_pop = 0;
  logic [31:0] cpu_wdata = '0, fab_wdata = '0;
  logic [31:0] cpu_rdata, fab_rdata;
  logic cpu_rvalid, cpu_err, cpu_full, cpu_empty;
  logic fab_busy, fab_done, fab_err, fab_full, fab_empty;
  logic [CW-1:0] cpu_count, fab_count;

  int ntests = 0, nfail = 0;
  logic [31:0] mdl[$];

  always #10 cpu_clk = ~cpu_clk;
  always #17 fab_clk = ~fab_clk;

  dc_job_stack #(.DEPTH(D)) i_dc_job_stack (
    .cpu_clk_i(cpu_clk), .cpu_rst_ni(cpu_rst_n), .cpu_push_i(cpu_push), .cpu_pop_i(cpu_pop),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cpu_rvalid_o(cpu_rvalid),
    .cpu_err_o(cpu_err), .cpu_full_o(cpu_full), .cpu_empty_o(cpu_empty), .cpu_count_o(cpu_count),
    .fab_clk_i(fab_clk), .fab_rst_ni(fab_rst_n), .fab_push_i(fab_push), .fab_pop_i(fab_pop),
    .fab_wdata_i(fab_wdata), .fab_rdata_o(fab_rdata), .fab_busy_o(fab_busy),
    .fab_done_o(fab_done), .fab_err_o(fab_err), .fab_full_o(fab_full),
    .fab_empty_o(fab_empty), .fab_count_o(fab_count));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge fab_clk);
    chk(fab_count == CW'(mdl.size()), "R5", "fab count settles", 32'(fab_count), mdl.size());
  endtask

  task automatic cpu_op(input bit push, input bit pop, input logic [31:0] data);
    logic [31:0] exp;
    int n;
    n = mdl.size();
    @(negedge cpu_clk);
    cpu_push = push; cpu_pop = pop; cpu_wdata = data;
    @(negedge cpu_clk);
    cpu_push = 0; cpu_pop = 0;
    if (push && pop) begin
      chk(cpu_rvalid && cpu_rdata == data, "R4", "pass-through data", cpu_rdata, data);
    end else if (push) begin
      if (n < D) begin
        mdl.push_back(data);
        chk(!cpu_err, "R2", "push accepted", 32'(cpu_err), 0);
      end else
        chk(cpu_err, "R3", "push when full err", 32'(cpu_err), 1);
    end else if (pop) begin
      if (n > 0) begin
        exp = mdl.pop_back();
        chk(cpu_rvalid && cpu_rdata == exp, "R2", "pop LIFO data", cpu_rdata, exp);
      end else
        chk(cpu_err && !cpu_rvalid, "R3", "pop when empty err", {cpu_err, cpu_rvalid}, 2);
    end
    chk(cpu_count == CW'(mdl.size()), push && pop ? "R4" : "R2", "cpu count",
        32'(cpu_count), mdl.size());
  endtask

  task automatic fab_op(input bit push, input bit pop, input logic [31:0] data);
    logic [31:0] exp;
    int n;
    bit seen;
    settle();
    n = mdl.size();
    @(negedge fab_clk);
    fab_push = push; fab_pop = pop; fab_wdata = data;
    @(negedge fab_clk);
    fab_push = 0; fab_pop = 0;
    if ((pop && n == 0) || (!pop && n == D)) begin
      chk(fab_err && !fab_busy && !fab_done, "R8", "refused at port", {fab_err, fab_busy}, 2);
    end else begin
      chk(fab_busy, pop ? "R6" : "R7", "busy after accept", 32'(fab_busy), 1);
      seen = 0;
      for (int k = 0; k < 60 && !seen; k++) begin
        @(negedge fab_clk);
        seen = fab_done;
      end
      chk(seen && !fab_err, pop ? "R6" : "R7", "done without err", 32'(fab_err), 0);
      if (pop) begin
        exp = mdl.pop_back();
        chk(fab_rdata == exp, "R6", "fab pop data", fab_rdata, exp);
      end else
        mdl.push_back(data);
    end
    settle();
  endtask

  initial begin
    #3_000_000;
    ntests++; nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge fab_clk);
    cpu_rst_n = 1; fab_rst_n = 1;
    @(negedge cpu_clk);
    chk(cpu_count == 0 && cpu_empty && !cpu_full && !cpu_rvalid && !cpu_err, "R1",
        "cpu reset", 32'(cpu_count), 0);
    @(negedge fab_clk);
    chk(fab_count == 0 && fab_empty && !fab_full && !fab_busy && !fab_done && !fab_err,
        "R1", "fab reset", 32'(fab_count), 0);

    // empty corners
    cpu_op(0, 1, 0);
    cpu_op(1, 1, 32'hA5A5_0001);
    fab_op(0, 1, 0);
    // fill to full, LIFO, full corners
    for (int i = 0; i < D; i++) cpu_op(1, 0, 32'h1000 + i);
    cpu_op(1, 0, 32'hDEAD);
    cpu_op(1, 1, 32'hBEEF);
    fab_op(1, 0, 32'h7777);
    fab_op(0, 1, 0);
    fab_op(1, 0, 32'h5151);
    cpu_op(0, 1, 0); // R7: returns fabric-pushed word
    fab_op(1, 1, 32'h9999); // R6: both high acts as pop

    // R9: request while busy is ignored
    settle();
    @(negedge fab_clk); fab_pop = 1;
    @(negedge fab_clk); fab_pop = 0; fab_push = 1; fab_wdata = 32'hCAFE;
    @(negedge fab_clk); fab_push = 0;
    for (int k = 0; k < 60 && !fab_done; k++) @(negedge fab_clk);
    void'(mdl.pop_back());
    settle();
    @(negedge cpu_clk);
    chk(cpu_count == CW'(mdl.size()), "R9", "push while busy ignored", 32'(cpu_count), mdl.size());

    // drain, then R10 race on the last word
    while (mdl.size() > 1) cpu_op(0, 1, 0);
    settle();
    fork
      begin
        @(negedge cpu_clk); cpu_pop = 1;
        @(negedge cpu_clk); cpu_pop = 0;
        chk(cpu_rvalid && cpu_rdata == mdl[0], "R10", "cpu wins last word", cpu_rdata, mdl[0]);
      end
      begin
        @(negedge fab_clk); fab_pop = 1;
        @(negedge fab_clk); fab_pop = 0;
        for (int k = 0; k < 60 && !fab_done; k++) @(negedge fab_clk);
        chk(fab_done && fab_err, "R10", "stale pop refused", {fab_done, fab_err}, 3);
      end
    join
    void'(mdl.pop_back());
    settle();
    @(negedge cpu_clk);
    chk(cpu_count == 0 && cpu_empty, "R10", "not over-popped", 32'(cpu_count), 0);

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      int r;
      r = $urandom % 12;
      if (r < 5)       cpu_op(1, 0, $urandom);
      else if (r < 8)  cpu_op(0, 1, 0);
      else if (r < 9)  cpu_op(1, 1, $urandom);
      else if (r < 10) fab_op(0, 1, 0);
      else             fab_op(1, 0, $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule